// File: doc/BRIEF.md
# Dual-Threshold Excursion Counter

This block watches a stream of signed 16-bit samples and compares each one against two programmable levels: a positive upper level and a negative lower level. Each threshold is an 8-bit magnitude scaled by 128. The block counts how many separate times the signal moves beyond each level. The two 4-bit counts are packed into one byte, and reading that byte clears it.

From the two counts the block derives two count conditions:

- **Sum condition:** the total number of excursions reaches a programmed required count.
- **Both-sides condition:** the sum condition holds and both counts are nonzero.

These conditions feed sticky status flags, together with a window-timer expiry flag and a new-sample flag. Each flag has its own enable bit. A single level interrupt output is high while any enabled flag is set.

Software or a host state machine reaches the block through a byte-wide register port. Samples arrive on a valid/ready stream. The block never applies back-pressure: `smp_ready` is held high, and every cycle with `smp_valid` high delivers one sample.

Top module: `thr_event_counter`

Register map (4-bit address):

| Address | Contents |
|---|---|
| 0x0 | Last sample, low byte (read only) |
| 0x1 | Last sample, high byte (read only) |
| 0x2 | Status |
| 0x3 | Count byte |
| 0x4 | Interrupt enable |
| 0x5 | Required count |
| 0x6 | Upper threshold |
| 0x7 | Lower threshold |
| 0x8 | Window length, bits 7:0 |
| 0x9 | Window length, bits 9:8 (in data bits 1:0) |

Status and enable share one bit layout:

| Bit | Flag |
|---|---|
| 0 | New sample |
| 1 | Window expiry |
| 2 | Both-sides count condition |
| 3 | Sum count condition |

Read data is registered: `reg_rdata` carries the value of the register addressed in a `reg_rd` cycle from the following clock edge onward.

## Requirements
- R1: Every cycle with `smp_valid` high accepts one sample (`smp_ready` is always 1). The sample becomes readable at addresses 0x0 (low byte) and 0x1 (high byte), and status bit 0 is set at the same edge.
- R2: A sample is above when it is greater than upper threshold × 128. It is below when it is less than −(lower threshold × 128). Both comparisons are signed, and a sample exactly equal to either level is inside.
- R3: An excursion is counted once, on the first sample beyond a level. It is counted again only after the signal has been beyond the other level or back inside. A direct jump from above to below counts a lower excursion.
- R4: The count byte (address 0x3) holds the upper excursion count in bits 7:4 and the lower excursion count in bits 3:0. Each count saturates at 15.
- R5: Reading the count byte returns its value and sets both counts to zero. If an excursion arrives in that same cycle, its count restarts at 1.
- R6: Status bit 3 is set when upper count + lower count is at least the required count (address 0x5, resets to 15). Status bit 2 is set when that holds and both counts are nonzero.
- R7: Status bits are sticky and are cleared by writing 1 to them at address 0x2. A set condition in the same cycle wins over the clear. The enable register at address 0x4 resets to 0.
- R8: `irq` is high exactly while some status bit and its matching enable bit are both 1.
- R9: The window length is 10 bits. Address 0x8 holds bits 7:0 and address 0x9 holds bits 9:8 in its data bits 1:0, and writing either address restarts the window. For a nonzero length W, the W-th accepted sample since the restart ends the window: it sets status bit 1 and clears both counts, and that sample's own excursion opens the new count. A length of 0 disables the timer.
- R10: After reset, status, counts, enable, thresholds and window length read 0 and the required count reads 0x0F. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample valid |
| smp_ready | output | 1 | Sample ready, constant 1 |
| smp_data | input | 16 | Signed sample |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The sample register, the new-sample flag and both counts change at the edge that accepts a sample. The two count flags follow one edge later, because they are derived from the registered counts. `irq` follows a status or enable change combinationally from those registers. Read data appears one edge after the `reg_rd` cycle, and the monitor compares it at the falling edge that follows. Before each register read the driver leaves at least two idle cycles after the last sample or write, so every flag that stimulus can raise has settled before it is sampled.

// File: rtl/thr_evt_pkg.sv
package thr_evt_pkg;
  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    RA_SMP_LO = 4'h0,
    RA_SMP_HI = 4'h1,
    RA_STATUS = 4'h2,
    RA_COUNT  = 4'h3,
    RA_ENABLE = 4'h4,
    RA_REQ    = 4'h5,
    RA_THR_UP = 4'h6,
    RA_THR_DN = 4'h7,
    RA_WIN_LO = 4'h8,
    RA_WIN_HI = 4'h9
  } reg_addr_e;

  localparam int ST_DATA = 0;
  localparam int ST_WIN  = 1;
  localparam int ST_AND  = 2;
  localparam int ST_OR   = 3;
  localparam int NSRC    = 4;

  localparam int LANE_DN = 0;
  localparam int LANE_UP = 1;

  typedef enum logic [1:0] {
    RG_INSIDE = 2'd0,
    RG_ABOVE  = 2'd1,
    RG_BELOW  = 2'd2
  } region_e;
endpackage

// File: rtl/thr_compare.sv
module thr_compare
  import thr_evt_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int THR_W    = 8,
  parameter int SCALE_SH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_acc,
  input  logic [SMP_W-1:0] smp_data,
  input  logic [THR_W-1:0] thr_up,
  input  logic [THR_W-1:0] thr_dn,
  output logic [1:0]       hit
);
  localparam int LW = SMP_W + 2;

  logic signed [LW-1:0] smp_x, up_lvl, dn_lvl;
  logic                 above, below;
  region_e              region_q, region_d;

  always_comb begin
    smp_x  = {{2{smp_data[SMP_W-1]}}, smp_data};
    up_lvl = LW'(thr_up) <<< SCALE_SH;
    dn_lvl = -(LW'(thr_dn) <<< SCALE_SH);
    above  = smp_x > up_lvl;
    below  = smp_x < dn_lvl;
    if (above)      region_d = RG_ABOVE;
    else if (below) region_d = RG_BELOW;
    else            region_d = RG_INSIDE;
    hit[LANE_UP] = smp_acc && above && (region_q != RG_ABOVE);
    hit[LANE_DN] = smp_acc && below && (region_q != RG_BELOW);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       region_q <= RG_INSIDE;
    else if (smp_acc) region_q <= region_d;
  end
endmodule

// File: rtl/excursion_counter.sv
module excursion_counter #(
  parameter int CNT_W = 4,
  parameter int LANES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [LANES-1:0]            hit,
  input  logic                        clr,
  output logic [LANES-1:0][CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt[g] <= '0;
      else if (clr)
        cnt[g] <= hit[g] ? CNT_W'(1) : '0;
      else if (hit[g] && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + CNT_W'(1);
    end
  end
endmodule

// File: rtl/window_timer.sv
module window_timer #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  input  logic [WIN_W-1:0] win_len,
  output logic             expire
);
  logic [WIN_W-1:0] tcnt_q;
  logic             armed;

  always_comb begin
    armed  = win_len != '0;
    expire = tick && armed && !restart && (tcnt_q == win_len - WIN_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart)
      tcnt_q <= '0;
    else if (tick && armed)
      tcnt_q <= expire ? '0 : tcnt_q + WIN_W'(1);
  end
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic            clr_wr,
  input  logic            en_wr,
  input  logic [NSRC-1:0] wmask,
  output logic [NSRC-1:0] status,
  output logic [NSRC-1:0] enable,
  output logic            irq
);
  logic [NSRC-1:0] clr_mask;

  always_comb begin
    clr_mask = clr_wr ? wmask : '0;
    irq      = |(status & enable);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_mask) | set;
      if (en_wr) enable <= wmask;
    end
  end
endmodule

// File: rtl/thr_event_counter.sv
module thr_event_counter
  import thr_evt_pkg::*;
#(
  parameter int SMP_W    = 16,
  parameter int DW       = 8,
  parameter int THR_W    = 8,
  parameter int SCALE_SH = 7,
  parameter int CNT_W    = 4,
  parameter int WIN_W    = 10,
  parameter int REQ_RST  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq
);
  localparam int SUM_W  = CNT_W + 1;
  localparam int WHI_W  = WIN_W - DW;
  localparam int CMP_W  = (DW > SUM_W) ? DW : SUM_W;

  logic              smp_acc;
  logic [SMP_W-1:0]  smp_q;
  logic [THR_W-1:0]  thr_up_q, thr_dn_q;
  logic [DW-1:0]     req_q;
  logic [WIN_W-1:0]  win_q;
  logic [1:0]        hit;
  logic [1:0][CNT_W-1:0] cnt;
  logic [CNT_W-1:0]  cnt_up, cnt_dn;
  logic [SUM_W-1:0]  cnt_sum;
  logic              cnt_clr, cnt_rd, win_restart, expire;
  logic              or_cond, and_cond;
  logic [NSRC-1:0]   st_set, status_q, enable_q;
  logic [DW-1:0]     rd_mux, rdata_q;
  reg_addr_e         addr;

  assign smp_ready = 1'b1;
  assign smp_acc   = smp_valid && smp_ready;
  assign addr      = reg_addr_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_q    <= '0;
      thr_up_q <= '0;
      thr_dn_q <= '0;
      req_q    <= DW'(REQ_RST);
      win_q    <= '0;
    end else begin
      if (smp_acc) smp_q <= smp_data;
      if (reg_wr) begin
        case (addr)
          RA_THR_UP: thr_up_q <= reg_wdata[THR_W-1:0];
          RA_THR_DN: thr_dn_q <= reg_wdata[THR_W-1:0];
          RA_REQ:    req_q    <= reg_wdata;
          RA_WIN_LO: win_q[DW-1:0]    <= reg_wdata;
          RA_WIN_HI: win_q[WIN_W-1:DW] <= reg_wdata[WHI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign win_restart = reg_wr && (addr == RA_WIN_LO || addr == RA_WIN_HI);
  assign cnt_rd      = reg_rd && (addr == RA_COUNT);
  assign cnt_clr     = cnt_rd || expire;

  thr_compare #(.SMP_W(SMP_W), .THR_W(THR_W), .SCALE_SH(SCALE_SH)) u_cmp (
    .clk(clk), .rst_n(rst_n), .smp_acc(smp_acc), .smp_data(smp_data),
    .thr_up(thr_up_q), .thr_dn(thr_dn_q), .hit(hit)
  );

  excursion_counter #(.CNT_W(CNT_W), .LANES(2)) u_cnt (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(cnt_clr), .cnt(cnt)
  );

  window_timer #(.WIN_W(WIN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .tick(smp_acc), .restart(win_restart),
    .win_len(win_q), .expire(expire)
  );

  always_comb begin
    cnt_up   = cnt[LANE_UP];
    cnt_dn   = cnt[LANE_DN];
    cnt_sum  = SUM_W'(cnt_up) + SUM_W'(cnt_dn);
    or_cond  = CMP_W'(cnt_sum) >= CMP_W'(req_q);
    and_cond = or_cond && (cnt_up != '0) && (cnt_dn != '0);
    st_set          = '0;
    st_set[ST_DATA] = smp_acc;
    st_set[ST_WIN]  = expire;
    st_set[ST_AND]  = and_cond;
    st_set[ST_OR]   = or_cond;
  end

  irq_status #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(st_set),
    .clr_wr(reg_wr && addr == RA_STATUS),
    .en_wr(reg_wr && addr == RA_ENABLE),
    .wmask(reg_wdata[NSRC-1:0]),
    .status(status_q), .enable(enable_q), .irq(irq)
  );

  always_comb begin
    case (addr)
      RA_SMP_LO: rd_mux = smp_q[DW-1:0];
      RA_SMP_HI: rd_mux = smp_q[SMP_W-1:DW];
      RA_STATUS: rd_mux = DW'(status_q);
      RA_COUNT:  rd_mux = {cnt_up, cnt_dn};
      RA_ENABLE: rd_mux = DW'(enable_q);
      RA_REQ:    rd_mux = req_q;
      RA_THR_UP: rd_mux = DW'(thr_up_q);
      RA_THR_DN: rd_mux = DW'(thr_dn_q);
      RA_WIN_LO: rd_mux = win_q[DW-1:0];
      RA_WIN_HI: rd_mux = DW'(win_q[WIN_W-1:DW]);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (reg_rd) rdata_q <= rd_mux;
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/thr_event_counter_chk.sv
module thr_event_counter_chk #(
  parameter int CNT_W = 4,
  parameter int DW    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic             reg_rd,
  input logic [3:0]       reg_addr,
  input logic             irq,
  input logic [3:0]       status,
  input logic [3:0]       enable,
  input logic [CNT_W-1:0] cnt_up,
  input logic [CNT_W-1:0] cnt_dn,
  input logic [DW-1:0]    req,
  input logic             cnt_clr
);
  localparam logic [CNT_W-1:0] CMAX = '1;
  logic [DW:0] sum_x;
  assign sum_x = (DW+1)'(cnt_up) + (DW+1)'(cnt_dn);

  // R1
  data_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> status[0]);

  // R4
  up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up == CMAX && !cnt_clr) |=> cnt_up == CMAX);

  // R4
  dn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_dn == CMAX && !cnt_clr) |=> cnt_dn == CMAX);

  // R5
  count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 4'h3) |=> (cnt_up <= CNT_W'(1) && cnt_dn <= CNT_W'(1)));

  // R6
  both_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_up != '0 && cnt_dn != '0 && sum_x >= (DW+1)'(req)) |=> (status[2] && status[3]));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq);
endmodule

bind thr_event_counter thr_event_counter_chk #(.CNT_W(CNT_W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .irq(irq), .status(status_q), .enable(enable_q),
  .cnt_up(cnt_up), .cnt_dn(cnt_dn), .req(req_q), .cnt_clr(cnt_clr)
);

// File: tb/tb_thr_event_counter.sv
module tb_thr_event_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid = 1'b0;
  logic        smp_ready;
  logic [15:0] smp_data = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic rd_seen = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  thr_event_counter dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // monitor: compares read data one edge after the read strobe
  always @(posedge clk) rd_seen <= reg_rd && rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s: got %02h exp %02h", t, reg_rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(1);
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    idle(1);
  endtask

  task automatic smp(input int v);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = 16'(v);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic chk_bit(input logic got, input logic e, input string t);
    total++;
    if (got !== e) begin
      bad++;
      $display("FAIL %s: got %0b exp %0b", t, got, e);
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout exp completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R10 reset state, R1 ready
    chk_bit(irq, 1'b0, "R10 irq after reset");
    chk_bit(smp_ready, 1'b1, "R1 ready");
    rd(4'h2, 8'h00, "R10 status reset");
    rd(4'h3, 8'h00, "R10 count reset");
    rd(4'h4, 8'h00, "R10 enable reset");
    rd(4'h5, 8'h0F, "R10 required count reset");
    rd(4'hF, 8'h00, "R10 unmapped");

    wr(4'h6, 8'd2);
    wr(4'h7, 8'd2);
    rd(4'h6, 8'h02, "R10 upper threshold readback");
    wr(4'h9, 8'hFF);
    rd(4'h9, 8'h03, "R9 window high two bits");
    wr(4'h9, 8'h00);

    // R1 sample capture and data flag
    smp(10); idle(2);
    rd(4'h2, 8'h01, "R1 data flag");
    rd(4'h0, 8'h0A, "R1 sample low");
    smp(-2); idle(2);
    rd(4'h1, 8'hFF, "R1 sample high");
    rd(4'h0, 8'hFE, "R1 sample low neg");
    wr(4'h2, 8'h01);
    rd(4'h2, 8'h00, "R7 write one clears");

    // R2 boundaries
    smp(256); smp(0); smp(-256); smp(0); idle(2);
    rd(4'h3, 8'h00, "R2 equal level is inside");
    smp(257); smp(0); smp(-257); smp(0); idle(2);
    rd(4'h3, 8'h11, "R2 just beyond both levels");
    rd(4'h3, 8'h00, "R5 count cleared by read");

    // R3 one count per excursion, direct jump
    smp(300); smp(400); smp(500); smp(0);
    smp(300); smp(0);
    smp(-300); smp(-400);
    smp(300); smp(-300); smp(0); idle(2);
    rd(4'h3, 8'h32, "R3 excursion counting");

    // R6 sum and both-sides conditions
    wr(4'h2, 8'h0F);
    wr(4'h5, 8'd3);
    smp(-300); smp(0); smp(-300); smp(0); idle(2);
    rd(4'h2, 8'h01, "R6 sum below required");
    smp(300); smp(0); idle(2);
    rd(4'h2, 8'h0D, "R6 sum and both sides");
    rd(4'h3, 8'h12, "R4 packed count");
    rd(4'h2, 8'h0D, "R7 flags sticky");
    wr(4'h2, 8'h0F);
    rd(4'h2, 8'h00, "R7 clear all");
    smp(-300); smp(0); smp(-300); smp(0); smp(-300); smp(0); idle(2);
    rd(4'h2, 8'h09, "R6 sum only, one side");
    rd(4'h3, 8'h03, "R4 lower only");

    // R8 interrupt masking
    chk_bit(irq, 1'b0, "R8 disabled");
    wr(4'h4, 8'h08);
    chk_bit(irq, 1'b1, "R8 enabled sum flag");
    wr(4'h4, 8'h04);
    chk_bit(irq, 1'b0, "R8 enabled flag clear");
    wr(4'h4, 8'h08);
    wr(4'h2, 8'h08);
    chk_bit(irq, 1'b0, "R8 after status clear");
    wr(4'h4, 8'h00);

    // R4 saturation
    wr(4'h2, 8'h0F);
    wr(4'h5, 8'd31);
    for (int i = 0; i < 20; i++) begin
      smp(300); smp(-300);
    end
    smp(0); idle(2);
    rd(4'h3, 8'hFF, "R4 saturate both");

    // R9 window timer
    wr(4'h2, 8'h0F);
    wr(4'h8, 8'd5);
    smp(300); smp(0); smp(0); smp(0); idle(2);
    rd(4'h2, 8'h01, "R9 window not yet ended");
    smp(0); idle(2);
    rd(4'h2, 8'h03, "R9 window expiry flag");
    rd(4'h3, 8'h00, "R9 counts cleared at expiry");
    wr(4'h4, 8'h02);
    chk_bit(irq, 1'b1, "R8 window irq");
    smp(300); idle(2);
    rd(4'h3, 8'h10, "R9 counting in new window");

    idle(4);
    summary();
  end
endmodule